// File: doc/BRIEF.md
# Three-Bank GPIO Controller

This block is a general-purpose I/O controller for seventeen pins. Pins 0 to 7 form bank 0, pins 8 to 15 form bank 1, and pin 16 is a bank of its own. Each bank has six byte-wide registers behind one read/write port:

- direction
- data
- inversion
- edge status
- output mode
- pin reserve

A global enable register turns each bank on or off.

Each pin can be an input or an output. An output can use push-pull or open-drain drive. One inversion bit per pin applies to the driven value and to the value read back. Both rising and falling edges on a pin are caught in a status register, and reading that register clears it. Pin inputs pass through a two-flop synchronizer before any logic samples them.

Software writes the enable register first. It then sets direction, mode and inversion for each bank, and moves outputs through the data register. A reserved pin is left to some other function: it is never driven, it reads as 0 and it records no edges.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset, every direction bit is 1 (input) and every other register is 0, including the bank enables. No pin is driven, and `reg_rdata` is 0.
- R2: The enable register is at address 56. It holds bank 0 in bit 0, bank 1 in bit 1 and bank 2 in bit 6. A disabled bank does not drive its pins, ignores writes, reads as 0 and records no edges.
- R3: A direction bit of 0 makes the pin an output. A direction bit of 1 makes it an input, with its output enable low.
- R4: In push-pull mode (mode bit 0), an output pin has `pin_oe` high and drives `pin_out` equal to its data latch XOR its inversion bit.
- R5: In open-drain mode (mode bit 1), an output whose inverted level is 1 is released (`pin_oe` low). An output whose inverted level is 0 is driven low.
- R6: The inversion bit flips both the driven level of an output and the level that a data read returns for an input.
- R7: A data read returns the synchronized pin level XOR inversion for inputs, and the latch for outputs. A data write changes the latch only for pins whose direction bit is 0.
- R8: A pin whose reserve bit is 1 is never driven, reads as 0 in the data register and never sets its status bit.
- R9: Each input passes through two flops. A level applied before clock edge k is seen by a data read strobed at edge k+2, and not by one strobed at edge k+1.
- R10: Each status bit is set by either edge of its synchronized input. A status read returns the bits and clears them. Writes to the status register have no effect.
- R11: An edge that lands in the same cycle as a status read is not returned by that read. It is kept for the next read.
- R12: Address bits [5:3] pick the bank (0 to 2) and bits [2:0] pick the field: 0 direction, 1 data, 2 inversion, 3 status, 4 mode, 5 reserve. Read data appears on `reg_rdata` in the cycle after the strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register address: bank and field |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pin_in | input | 17 | Pin input levels |
| pin_oe | output | 17 | Per-pin output enable |
| pin_out | output | 17 | Per-pin driven level |

## Verification
The bench times a status read so that a fresh edge reaches the status register in the same cycle as the read. A design that cleared after merging the edge would lose that edge for good.

It strobes data reads one and two cycles after an input change. A design with one synchronizer flop too few or too many would return the new level a cycle early or late.

It writes the data register while some pins are inputs. A design that ignored the direction mask would show a changed latch once those pins turned into outputs.

It also checks two further cases:
- Open-drain pins at both levels: a wrong mode decode would drive an open-drain pin high.
- Reserved pins and a disabled single-pin bank: a wrong decode would drive those pins or let them report edges.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam logic [ADDR_W-1:0] EN_ADDR = 6'd56;

    typedef enum logic [2:0] {
        FLD_DIR  = 3'd0,
        FLD_DATA = 3'd1,
        FLD_INV  = 3'd2,
        FLD_STAT = 3'd3,
        FLD_MODE = 3'd4,
        FLD_RSV  = 3'd5
    } fld_e;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_s;

    sync_s sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = raw;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign synced = sync_q.s2;
endmodule

// File: rtl/pinbank_bank.sv
module pinbank_bank import pinbank_pkg::*; #(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr,
    input  logic              rd,
    input  logic [2:0]        fld,
    input  logic [DATA_W-1:0] wdata,
    input  logic [W-1:0]      pin_sync,
    output logic [DATA_W-1:0] rdata,
    output logic [W-1:0]      oe,
    output logic [W-1:0]      dout
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] lat;
        logic [W-1:0] inv;
        logic [W-1:0] stat;
        logic [W-1:0] mode;
        logic [W-1:0] rsv;
        logic [W-1:0] prev;
    } bank_s;

    bank_s        bank_d, bank_q;
    logic [W-1:0] usable, lvl, edg_v, rdv;
    logic         stat_rd;

    always_comb begin
        usable  = {W{en}} & ~bank_q.rsv;
        lvl     = bank_q.lat ^ bank_q.inv;
        edg_v   = (pin_sync ^ bank_q.prev) & usable;
        stat_rd = rd && en && (fld == FLD_STAT);

        bank_d      = bank_q;
        bank_d.prev = pin_sync;
        // clear on read, then merge any edge arriving this cycle
        bank_d.stat = (stat_rd ? '0 : bank_q.stat) | edg_v;

        if (wr && en) begin
            case (fld)
                FLD_DIR:  bank_d.dir  = wdata[W-1:0];
                FLD_DATA: bank_d.lat  = (bank_q.lat & bank_q.dir) | (wdata[W-1:0] & ~bank_q.dir);
                FLD_INV:  bank_d.inv  = wdata[W-1:0];
                FLD_MODE: bank_d.mode = wdata[W-1:0];
                FLD_RSV:  bank_d.rsv  = wdata[W-1:0];
                default: ;
            endcase
        end

        rdv = '0;
        if (en) begin
            case (fld)
                FLD_DIR:  rdv = bank_q.dir;
                FLD_DATA: rdv = usable & ((bank_q.dir & (pin_sync ^ bank_q.inv)) |
                                          (~bank_q.dir & bank_q.lat));
                FLD_INV:  rdv = bank_q.inv;
                FLD_STAT: rdv = bank_q.stat;
                FLD_MODE: rdv = bank_q.mode;
                FLD_RSV:  rdv = bank_q.rsv;
                default:  rdv = '0;
            endcase
        end
        rdata        = '0;
        rdata[W-1:0] = rdv;

        oe   = usable & ~bank_q.dir & ~(bank_q.mode & lvl);
        dout = oe & lvl & ~bank_q.mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q     <= '0;
            bank_q.dir <= '1;
        end else begin
            bank_q <= bank_d;
        end
    end

    assert_wr_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !en) |=> ($stable(bank_q.dir) && $stable(bank_q.lat) && $stable(bank_q.inv)
                         && $stable(bank_q.mode) && $stable(bank_q.rsv)));

    assert_lat_inputs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && en && fld == FLD_DATA) |=>
        ((bank_q.lat & $past(bank_q.dir)) == ($past(bank_q.lat) & $past(bank_q.dir))));

    assert_od_never_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((oe & bank_q.mode & dout) == '0));

    assert_stat_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && edg_v == '0) |=> (bank_q.stat == '0));

    assert_edge_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (bank_q.stat == $past(edg_v)));
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl import pinbank_pkg::*; #(
    parameter int FULL_W      = 8,
    parameter int NFULL       = 2,
    parameter int TAIL_W      = 1,
    parameter int TAIL_EN_BIT = 6,
    localparam int NBANK      = NFULL + 1,
    localparam int NPINS      = NFULL * FULL_W + TAIL_W,
    localparam int SEL_W      = ADDR_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pin_out
);
    typedef struct packed {
        logic [NBANK-1:0]  en;
        logic [DATA_W-1:0] rdata;
    } top_s;

    top_s              top_d, top_q;
    logic [SEL_W-1:0]  sel;
    logic [NPINS-1:0]  pin_s;
    logic [DATA_W-1:0] bank_rd [NBANK];
    logic [DATA_W-1:0] rmux;

    assign sel = reg_addr[ADDR_W-1:3];

    pinbank_sync #(.W(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pin_in),
        .synced (pin_s)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        localparam int W  = (g < NFULL) ? FULL_W : TAIL_W;
        localparam int LO = g * FULL_W;
        pinbank_bank #(.W(W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (top_q.en[g]),
            .wr       (reg_wr && (sel == SEL_W'(g))),
            .rd       (reg_rd && (sel == SEL_W'(g))),
            .fld      (reg_addr[2:0]),
            .wdata    (reg_wdata),
            .pin_sync (pin_s[LO +: W]),
            .rdata    (bank_rd[g]),
            .oe       (pin_oe[LO +: W]),
            .dout     (pin_out[LO +: W])
        );
    end

    always_comb begin
        top_d = top_q;
        if (reg_wr && reg_addr == EN_ADDR) begin
            for (int g = 0; g < NFULL; g++) top_d.en[g] = reg_wdata[g];
            top_d.en[NFULL] = reg_wdata[TAIL_EN_BIT];
        end

        rmux = '0;
        if (reg_addr == EN_ADDR) begin
            for (int g = 0; g < NFULL; g++) rmux[g] = top_q.en[g];
            rmux[TAIL_EN_BIT] = top_q.en[NFULL];
        end else begin
            for (int g = 0; g < NBANK; g++)
                if (sel == SEL_W'(g)) rmux = bank_rd[g];
        end
        if (reg_rd) top_d.rdata = rmux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign reg_rdata = top_q.rdata;

    assert_tail_enable_bit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == EN_ADDR) |=> (top_q.en[NFULL] == $past(reg_wdata[TAIL_EN_BIT])));

    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/pinbank_ctrl_tb.sv
`timescale 1ns/1ps
module pinbank_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [16:0] pin_in = '0;
    logic [16:0] pin_oe, pin_out;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pinbank_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    // behavioural reference state, one bit per pin
    logic [16:0] dir_m, lat_m, inv_m, st_m, mode_m, rsv_m, s1, s2, s3;
    logic [16:0] dir_n, lat_n, inv_n, st_n, mode_n, rsv_n, use_v, edg;
    logic [2:0]  en_m, en_n;
    logic [7:0]  rd_m;
    logic [16:0] eoe, eout;

    function automatic int bwidth(int b);
        return (b == 2) ? 1 : 8;
    endfunction

    function automatic logic [7:0] mread(logic [5:0] a);
        logic [7:0] r;
        int b, f, p;
        r = '0;
        b = int'(a[5:3]);
        f = int'(a[2:0]);
        if (a == 6'd56) return {1'b0, en_m[2], 4'b0000, en_m[1], en_m[0]};
        if (b > 2) return '0;
        if (!en_m[b]) return '0;
        for (int k = 0; k < bwidth(b); k++) begin
            p = b * 8 + k;
            case (f)
                0: r[k] = dir_m[p];
                1: r[k] = rsv_m[p] ? 1'b0 : (dir_m[p] ? (s2[p] ^ inv_m[p]) : lat_m[p]);
                2: r[k] = inv_m[p];
                3: r[k] = st_m[p];
                4: r[k] = mode_m[p];
                5: r[k] = rsv_m[p];
                default: r[k] = 1'b0;
            endcase
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            dir_m = '1; lat_m = '0; inv_m = '0; st_m = '0; mode_m = '0; rsv_m = '0;
            s1 = '0; s2 = '0; s3 = '0; en_m = '0; rd_m = '0;
        end else begin
            for (int p = 0; p < 17; p++) begin
                use_v[p] = en_m[p / 8] && !rsv_m[p];
                edg[p]   = use_v[p] && (s2[p] != s3[p]);
            end
            dir_n = dir_m; lat_n = lat_m; inv_n = inv_m; mode_n = mode_m; rsv_n = rsv_m;
            en_n = en_m;
            st_n = st_m | edg;
            if (reg_rd) begin
                rd_m = mread(reg_addr);
                if (reg_addr[5:3] < 3 && reg_addr[2:0] == 3'd3 && en_m[reg_addr[5:3]])
                    for (int k = 0; k < bwidth(int'(reg_addr[5:3])); k++)
                        st_n[int'(reg_addr[5:3]) * 8 + k] = edg[int'(reg_addr[5:3]) * 8 + k];
            end
            if (reg_wr) begin
                if (reg_addr == 6'd56) en_n = {reg_wdata[6], reg_wdata[1], reg_wdata[0]};
                else if (reg_addr[5:3] < 3 && en_m[reg_addr[5:3]]) begin
                    for (int k = 0; k < bwidth(int'(reg_addr[5:3])); k++) begin
                        int p;
                        p = int'(reg_addr[5:3]) * 8 + k;
                        case (reg_addr[2:0])
                            3'd0: dir_n[p]  = reg_wdata[k];
                            3'd1: if (!dir_m[p]) lat_n[p] = reg_wdata[k];
                            3'd2: inv_n[p]  = reg_wdata[k];
                            3'd4: mode_n[p] = reg_wdata[k];
                            3'd5: rsv_n[p]  = reg_wdata[k];
                            default: ;
                        endcase
                    end
                end
            end
            dir_m = dir_n; lat_m = lat_n; inv_m = inv_n; mode_m = mode_n; rsv_m = rsv_n;
            st_m = st_n; en_m = en_n;
            s3 = s2; s2 = s1; s1 = pin_in;
        end
        #1;
        for (int p = 0; p < 17; p++) begin
            logic lv, u;
            u       = en_m[p / 8] && !rsv_m[p];
            lv      = lat_m[p] ^ inv_m[p];
            eoe[p]  = u && !dir_m[p] && !(mode_m[p] && lv);
            eout[p] = eoe[p] && !mode_m[p] && lv;
        end
        checks++;
        if (pin_oe !== eoe || pin_out !== eout || reg_rdata !== rd_m) begin
            errors++;
            $display("FAIL R3,R4,R5,R7 model: oe=%h out=%h rd=%h expected oe=%h out=%h rd=%h",
                     pin_oe, pin_out, reg_rdata, eoe, eout, rd_m);
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, logic [7:0] exp, string tag);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        chk(tag, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata", 32'(reg_rdata), 0);
        chk("R1 oe", 32'(pin_oe), 0);
        rd(6'd56, 8'h00, "R1 enable");
        rd(6'd0, 8'h00, "R2 disabled read");
        wr(6'd0, 8'h00);
        wr(6'd56, 8'h43);
        rd(6'd0, 8'hFF, "R2 ignored write / R1 dir");
        rd(6'd56, 8'h43, "R12 enable map");
        rd(6'd16, 8'h01, "R1 tail dir");
        chk("R3 inputs undriven", 32'(pin_oe), 0);
        // bank 0 outputs
        wr(6'd1, 8'hFF);
        wr(6'd0, 8'hF0);
        chk("R7 input write ignored oe", 32'(pin_oe[7:0]), 32'h0F);
        chk("R7 input write ignored out", 32'(pin_out[7:0]), 32'h00);
        wr(6'd1, 8'h05);
        chk("R4 push-pull", 32'(pin_out[7:0]), 32'h05);
        wr(6'd2, 8'h0C);
        chk("R6 output inversion", 32'(pin_out[7:0]), 32'h09);
        pin_in[5:4] = 2'b11;
        wr(6'd2, 8'h8C);
        idle(3);
        rd(6'd1, 8'hB5, "R6 input inversion / R7");
        rd(6'd3, 8'h30, "R10 status");
        rd(6'd3, 8'h00, "R10 cleared");
        wr(6'd4, 8'h03);
        chk("R5 open-drain oe", 32'(pin_oe[3:0]), 32'hE);
        chk("R5 open-drain out", 32'(pin_out[3:0]), 32'h8);
        wr(6'd5, 8'h04);
        chk("R8 reserved oe", 32'(pin_oe[3:0]), 32'hA);
        rd(6'd1, 8'hB1, "R8 reserved reads 0");
        pin_in[2] = 1'b1;
        idle(4);
        rd(6'd3, 8'h00, "R8 no edge");
        pin_in[2] = 1'b0;
        idle(4);
        // synchronizer latency on bank 1
        pin_in[8] = 1'b1;
        rd(6'd9, 8'h00, "R9 edge k");
        rd(6'd9, 8'h00, "R9 edge k+1");
        rd(6'd9, 8'h01, "R9 edge k+2");
        rd(6'd11, 8'h01, "R10 rising");
        wr(6'd11, 8'hFF);
        rd(6'd11, 8'h00, "R10 write ignored");
        pin_in[9] = 1'b1;
        rd(6'd11, 8'h00, "R11 k");
        rd(6'd11, 8'h00, "R11 k+1");
        rd(6'd11, 8'h00, "R11 collide");
        rd(6'd11, 8'h02, "R11 kept");
        pin_in[8] = 1'b0;
        idle(4);
        rd(6'd11, 8'h01, "R10 falling");
        // single-pin bank
        wr(6'd16, 8'h00);
        chk("R3 tail output oe", 32'(pin_oe[16]), 1);
        chk("R4 tail out low", 32'(pin_out[16]), 0);
        wr(6'd17, 8'hFF);
        chk("R4 tail out high", 32'(pin_out[16]), 1);
        rd(6'd16, 8'h00, "R12 tail dir");
        wr(6'd56, 8'h03);
        chk("R2 tail disabled oe", 32'(pin_oe[16]), 0);
        rd(6'd17, 8'h00, "R2 tail disabled read");
        rd(6'd56, 8'h03, "R12 enable readback");
        idle(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule